// File: doc/BRIEF.md
# Nibble-Split Adder with Decimal Carry Selection

This block is the add/subtract core of an 8-bit processor datapath. It builds the byte adder from two 4-bit halves chained by a nibble carry. Beside each half's ordinary binary carry, the block computes a decimal carry at the same time. In decimal add mode, a multiplexer passes the decimal carry on instead of the binary one. The selected low-half carry is the carry into the upper half, and it is also the half-carry output. The selected upper-half carry is the carry-out.

The sum leaves the block uncorrected. Any nibble above 9 is left for a later adjust stage, which uses the half-carry and carry-out outputs to decide its corrections.

Subtraction inverts the second operand and uses carry-clear-means-borrow. Because of this, in decimal subtract the carries are the plain nibble borrow indications. The N, V and Z flags come out with the sum. The block has no clock and no state, so its outputs follow the current inputs only.

Top module: `nibble_dec_alu`

## Requirements
- R1: The upper nibble of `sum_raw` equals the low four bits of A[7:4] + B'[7:4] + `half_carry`. Here B' is B when `sub_en`=0 and ~B when `sub_en`=1.
- R2: In decimal add (`dec_en`=1, `sub_en`=0), `half_carry` is 1 exactly when A[3:0] + B[3:0] + `carry_in` is greater than 9. The lower nibble of `sum_raw` is the low four bits of that sum, with no correction.
- R3: In decimal add, `carry_out` is 1 exactly when A[7:4] + B[7:4] + `half_carry` is greater than 9. For example, A=0x44, B=0x56, `carry_in`=0 gives `sum_raw`=0xAA, `half_carry`=1 and `carry_out`=1.
- R4: In subtract, with either value of `dec_en`, the carries mean "no borrow". `half_carry` is 1 exactly when A[3:0] >= B[3:0] + (1 - `carry_in`). `carry_out` is 1 exactly when A[7:4] >= B[7:4] + (1 - `half_carry`). `sum_raw` is (A - B - (1 - `carry_in`)) mod 256.
- R5: With `dec_en`=0, {`carry_out`, `sum_raw`} equals A + B' + `carry_in`, and `half_carry` is the carry out of bit 3 of that addition.
- R6: `flag_n` equals bit 7 of `sum_raw`.
- R7: `flag_z` is 1 exactly when (A + B' + `carry_in`) mod 256 is zero. This binary result is used in decimal mode too, so it can differ from `sum_raw`.
- R8: `flag_v` is 1 exactly when the signed binary result A + B' + `carry_in` lies outside -128..127, with A and B' read as two's-complement values.
- R9: All outputs are combinational functions of the present inputs. A new input vector is reflected without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry in (1 = no borrow when subtracting) |
| sub_en | input | 1 | 1 selects subtract |
| dec_en | input | 1 | 1 selects decimal carry rules |
| sum_raw | output | 8 | Uncorrected nibble-wise sum |
| half_carry | output | 1 | Selected carry out of the low nibble |
| carry_out | output | 1 | Selected carry out of the high nibble |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Signed overflow of the binary operation |
| flag_z | output | 1 | Binary result is zero |

## Verification
Every input vector is checked against four properties:
- the upper nibble of the sum agrees with the selected half-carry;
- the binary-mode carry-out and sum agree with a full-width addition;
- the decimal half-carry and borrow rules hold on the low nibble;
- N tracks the sum's top bit.

The exact decimal carry-out threshold and the Z and V flags are left to the bench. So are the worked 0x44 + 0x56 case and the independence from any clock edge. The bench compares every output against arithmetic over the full operand space, in all four mode combinations and for both carry-in values.

// File: rtl/nda_pkg.sv
package nda_pkg;
  localparam int NIB_W     = 4;
  localparam int DEC_LIMIT = 9;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
  } nda_flags_t;
endpackage

// File: rtl/nda_operand_cond.sv
module nda_operand_cond #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             invert,
  output logic [WIDTH-1:0] b_out
);
  always_comb begin
    b_out = invert ? ~b_in : b_in;
  end
endmodule

// File: rtl/nda_nibble_add.sv
module nda_nibble_add
  import nda_pkg::*;
#(
  parameter int NW    = NIB_W,
  parameter int LIMIT = DEC_LIMIT
) (
  input  logic [NW-1:0] a,
  input  logic [NW-1:0] b,
  input  logic          cin,
  input  logic          use_dec,
  output logic [NW-1:0] sum,
  output logic          cout
);
  logic [NW:0] wide;
  logic        bin_c;
  logic        dec_c;

  always_comb begin
    wide  = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, cin};
    bin_c = wide[NW];
    dec_c = (wide > (NW+1)'(LIMIT));
    sum   = wide[NW-1:0];
    cout  = use_dec ? dec_c : bin_c;
  end
endmodule

// File: rtl/nda_flag_unit.sv
module nda_flag_unit
  import nda_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b_eff,
  input  logic             cin,
  input  logic [WIDTH-1:0] raw,
  output nda_flags_t       flags
);
  logic [WIDTH-1:0] bin_sum;

  always_comb begin
    bin_sum    = a + b_eff + WIDTH'(cin);
    flags.neg  = raw[WIDTH-1];
    flags.zero = (bin_sum == '0);
    flags.ovf  = (a[WIDTH-1] == b_eff[WIDTH-1]) && (bin_sum[WIDTH-1] != a[WIDTH-1]);
  end
endmodule

// File: rtl/nibble_dec_alu.sv
module nibble_dec_alu
  import nda_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             sub_en,
  input  logic             dec_en,
  output logic [WIDTH-1:0] sum_raw,
  output logic             half_carry,
  output logic             carry_out,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_z
);
  localparam int NIBS = WIDTH / NIB_W;

  logic [WIDTH-1:0] b_eff;
  logic [NIBS:0]    chain;
  logic             dec_add;
  nda_flags_t       flags;

  assign dec_add  = dec_en & ~sub_en;
  assign chain[0] = carry_in;

  nda_operand_cond #(.WIDTH(WIDTH)) i_cond (
    .b_in   (op_b),
    .invert (sub_en),
    .b_out  (b_eff)
  );

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    nda_nibble_add #(.NW(NIB_W), .LIMIT(DEC_LIMIT)) i_nib (
      .a       (op_a[g*NIB_W +: NIB_W]),
      .b       (b_eff[g*NIB_W +: NIB_W]),
      .cin     (chain[g]),
      .use_dec (dec_add),
      .sum     (sum_raw[g*NIB_W +: NIB_W]),
      .cout    (chain[g+1])
    );
  end

  assign half_carry = chain[1];
  assign carry_out  = chain[NIBS];

  nda_flag_unit #(.WIDTH(WIDTH)) i_flags (
    .a     (op_a),
    .b_eff (b_eff),
    .cin   (carry_in),
    .raw   (sum_raw),
    .flags (flags)
  );

  assign flag_n = flags.neg;
  assign flag_v = flags.ovf;
  assign flag_z = flags.zero;
endmodule

// File: rtl/nda_checker.sv
module nda_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             carry_in,
  input logic             sub_en,
  input logic             dec_en,
  input logic [WIDTH-1:0] sum_raw,
  input logic             half_carry,
  input logic             carry_out,
  input logic             flag_n,
  input logic             flag_v,
  input logic             flag_z
);
  logic [WIDTH-1:0] bx;
  logic [4:0]       lo5;
  logic [4:0]       hi5;
  logic [WIDTH:0]   full;

  always_comb begin
    bx   = sub_en ? ~op_b : op_b;
    lo5  = {1'b0, op_a[3:0]} + {1'b0, bx[3:0]} + {4'b0, carry_in};
    hi5  = {1'b0, op_a[7:4]} + {1'b0, bx[7:4]} + {4'b0, half_carry};
    full = {1'b0, op_a} + {1'b0, bx} + {{WIDTH{1'b0}}, carry_in};

    p_high_nibble_r1: assert (sum_raw[7:4] == hi5[3:0])
      else $error("high nibble does not follow half carry");
    p_binary_mode_r5: assert (dec_en || ({carry_out, sum_raw} == full))
      else $error("binary sum/carry mismatch");
    p_dec_half_carry_r2: assert (!(dec_en && !sub_en) || (half_carry == (lo5 > 5'd9)))
      else $error("decimal half carry mismatch");
    p_sub_borrow_r4: assert (!sub_en ||
        (half_carry == ({1'b0, op_a[3:0]} >= {1'b0, op_b[3:0]} + {4'b0, ~carry_in})))
      else $error("subtract nibble borrow mismatch");
    p_flag_n_r6: assert (flag_n == sum_raw[WIDTH-1])
      else $error("N flag mismatch");
  end
endmodule

bind nibble_dec_alu nda_checker #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_nibble_dec_alu.sv
module test_nibble_dec_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a, op_b;
  logic       carry_in, sub_en, dec_en;
  logic [7:0] sum_raw;
  logic       half_carry, carry_out, flag_n, flag_v, flag_z;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  nibble_dec_alu i_nibble_dec_alu (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .sub_en(sub_en), .dec_en(dec_en),
    .sum_raw(sum_raw), .half_carry(half_carry), .carry_out(carry_out),
    .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%02h b=%02h cin=%0d sub=%0d dec=%0d actual=%0h expected=%0h",
               req, op_a, op_b, carry_in, sub_en, dec_en, act, exp);
    end
  endtask

  task automatic apply_and_check(input int a, input int b, input int c, input int s, input int d);
    int bb, full, lo, hi, e_sum, e_hc, e_co, sa, sb, r, e_v, e_z;
    op_a = 8'(a); op_b = 8'(b); carry_in = c[0]; sub_en = s[0]; dec_en = d[0];
    #2;
    bb    = s ? 255 - b : b;
    full  = a + bb + c;
    e_z   = ((full % 256) == 0) ? 1 : 0;
    sa    = (a > 127) ? a - 256 : a;
    sb    = (b > 127) ? b - 256 : b;
    r     = s ? sa - sb - (1 - c) : sa + sb + c;
    e_v   = (r > 127 || r < -128) ? 1 : 0;
    if (d && !s) begin
      lo    = (a % 16) + (b % 16) + c;
      e_hc  = (lo > 9) ? 1 : 0;
      hi    = (a / 16) + (b / 16) + e_hc;
      e_co  = (hi > 9) ? 1 : 0;
      e_sum = (hi % 16) * 16 + (lo % 16);
      chk("R2 half_carry", int'(half_carry), e_hc);
      chk("R3 carry_out", int'(carry_out), e_co);
      chk("R1/R2 sum_raw", int'(sum_raw), e_sum);
    end else if (s) begin
      e_hc  = ((a % 16) >= (b % 16) + (1 - c)) ? 1 : 0;
      e_co  = ((a / 16) >= (b / 16) + (1 - e_hc)) ? 1 : 0;
      e_sum = (a - b - (1 - c) + 256) % 256;
      chk("R4 half_carry", int'(half_carry), e_hc);
      chk("R4 carry_out", int'(carry_out), e_co);
      chk("R4 sum_raw", int'(sum_raw), e_sum);
    end else begin
      e_hc = (((a % 16) + (b % 16) + c) > 15) ? 1 : 0;
      chk("R5 half_carry", int'(half_carry), e_hc);
      chk("R5 carry_out", int'(carry_out), (full > 255) ? 1 : 0);
      chk("R5 sum_raw", int'(sum_raw), full % 256);
    end
    chk("R6 flag_n", int'(flag_n), int'(sum_raw[7]));
    chk("R7 flag_z", int'(flag_z), e_z);
    chk("R8 flag_v", int'(flag_v), e_v);
  endtask

  initial begin
    #(4_000_000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    op_a = '0; op_b = '0; carry_in = 1'b0; sub_en = 1'b0; dec_en = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #3;
    // Idle vector: all-zero inputs give zero sum with Z set
    chk("R7 idle flag_z", int'(flag_z), 1);
    chk("R5 idle sum_raw", int'(sum_raw), 0);

    // Worked decimal example
    apply_and_check(8'h44, 8'h56, 0, 0, 1);
    chk("R3 example sum_raw", int'(sum_raw), 8'hAA);
    chk("R3 example carry_out", int'(carry_out), 1);
    chk("R2 example half_carry", int'(half_carry), 1);

    // R9: outputs follow a new vector with no clock edge in between
    @(posedge clk); #3;
    op_a = 8'h0F; op_b = 8'h01; carry_in = 1'b0; sub_en = 1'b0; dec_en = 1'b0;
    #1;
    chk("R9 binary sum no edge", int'(sum_raw), 8'h10);
    dec_en = 1'b1;
    #1;
    chk("R9 decimal sum no edge", int'(sum_raw), 8'h10);
    chk("R9 decimal half no edge", int'(half_carry), 1);

    // Exhaustive sweep over both operands, carry-in and all modes
    for (int d = 0; d < 2; d++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
              apply_and_check(a, b, c, s, d);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule